// File: doc/BRIEF.md
# Burst-Mode Manchester Line Decoder

This block turns a bi-phase-level serial line into a recovered bit clock and an inverted data bit. A one arrives as a falling transition in the middle of its cell and a zero as a rising one. The block runs from a local sampling clock that is `OSR` times the nominal baud rate. It brings the asynchronous line into that domain through a short flop chain. It times every transition against the last one it took as a mid-cell transition, and treats a transition that comes too early as a cell-boundary transition, which carries no data.

There is no phase-locked loop and no training pattern. After a quiet line the decoder waits in a hunt state and treats the first transition it sees as a mid-cell transition. So the first bit of a burst comes out within one cell. Each accepted mid-cell transition pulls the recovered clock low for half a nominal cell and loads the inverted bit at that same edge. The falling edge therefore follows the transmitter's own mid-cell timing, and the data is settled well before the next rising edge. There is exactly one rising edge for every received bit.

Top module: `mdec_top`

## Requirements
- R1: A falling line transition accepted as mid-cell decodes to 1, and a rising one decodes to 0. `datan_o` carries the inverse of the decoded bit, so it is 0 after a one and 1 after a zero.
- R2: Every received bit yields exactly one rising edge of `rclk_o`. On that edge `datan_o` holds the inverse of that bit, including the first bit of a burst.
- R3: `rclk_o` falls exactly `SYNC_STAGES + 1` sampling-clock edges after the `rx_i` transition that was accepted as mid-cell.
- R4: `datan_o` changes only in the cycle where `rclk_o` falls. It stays constant across the following rising edge.
- R5: Each low phase of `rclk_o` lasts exactly `OSR/2` sampling cycles. `rclk_o` then stays high until the next accepted mid-cell transition.
- R6: Outside the hunt state, a transition is taken as mid-cell only when it comes at least ceil(3*`OSR`/4) sampling cycles after the previous accepted one (6 for `OSR` = 8). An earlier transition changes neither output.
- R7: Once 2*`OSR` sampling cycles pass without an accepted transition, the decoder enters hunt and `rclk_o` stays high. The next transition of either polarity is then accepted as mid-cell.
- R8: Bursts of random data decode without error at the nominal rate and at rates 15% above and below it. Each burst starts from a low idle line with a zero bit.
- R9: While `rst_ni` is low, and right after it rises, `rclk_o` is 1 and `datan_o` is 1, and the decoder is in hunt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, `OSR` times the nominal baud rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous bi-phase-level serial line |
| rclk_o | output | 1 | Recovered bit clock; data is valid at its rising edge |
| datan_o | output | 1 | Inverted decoded data bit |

## Verification
The hardest cases are the rate extremes. At +15% a mid-cell transition lands only a cycle or two past the acceptance threshold, and at -15% a boundary transition lands just under it. An off-by-one in the threshold would drop bits at one extreme or invent extra bits at the other, and either way the count of recovered rising edges would be wrong. A directed pair of transitions spaced 5 and then 6 cycles apart pins the threshold exactly. A transition after a long quiet line must be accepted whatever its polarity; a decoder that kept stale timing would skip the first bit of a burst. The monitor also measures every low pulse and watches the data line between clock edges, so a pulse of the wrong length or data that moves while the clock is high shows up at once.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Minimum spacing, in sampling cycles, for a transition to count as mid-cell.
  function automatic int mid_gap_min(input int osr);
    return (3 * osr + 3) / 4;
  endfunction

  // Quiet interval after which the decoder falls back to hunting.
  function automatic int idle_gap(input int osr);
    return 2 * osr;
  endfunction

  // Length of the recovered clock low phase.
  function automatic int low_len(input int osr);
    return osr / 2;
  endfunction

  // High-to-low mid-cell transition means one, low-to-high means zero.
  function automatic logic decode_bit(input logic prev, input logic now);
    return prev & ~now;
  endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mdec_edge_timer.sv
module mdec_edge_timer
  import mdec_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_s_i,
  output logic edge_o,
  output logic mid_o,
  output logic bit_o,
  output logic hunt_o
);

  localparam int IDLE   = idle_gap(OSR);
  localparam int MINGAP = mid_gap_min(OSR);
  localparam int CW     = $clog2(IDLE + 1);

  logic          rx_q;
  logic [CW-1:0] gap_q;
  logic          hunt_q;
  logic          far_enough;

  always_comb begin
    edge_o     = rx_s_i ^ rx_q;
    far_enough = (int'(gap_q) + 1) >= MINGAP;
    mid_o      = edge_o & (hunt_q | far_enough);
    bit_o      = decode_bit(rx_q, rx_s_i);
    hunt_o     = hunt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= 1'b0;
      gap_q  <= CW'(IDLE);
      hunt_q <= 1'b1;
    end else begin
      rx_q <= rx_s_i;
      if (mid_o) begin
        gap_q  <= '0;
        hunt_q <= 1'b0;
      end else if (int'(gap_q) != IDLE) begin
        gap_q <= gap_q + 1'b1;
      end else begin
        hunt_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdec_clkgen.sv
module mdec_clkgen
  import mdec_pkg::*;
#(
  parameter int OSR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mid_i,
  input  logic bit_i,
  output logic rclk_o,
  output logic datan_o
);

  localparam int HALF = low_len(OSR);
  localparam int LW   = $clog2(HALF + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rclk_o  <= 1'b1;
      datan_o <= 1'b1;
      left_q  <= '0;
    end else if (mid_i) begin
      rclk_o  <= 1'b0;
      datan_o <= ~bit_i;
      left_q  <= LW'(HALF - 1);
    end else if (!rclk_o) begin
      if (left_q == '0) rclk_o <= 1'b1;
      else              left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/mdec_top.sv
module mdec_top #(
  parameter int OSR         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rclk_o,
  output logic datan_o
);

  // Internal events, named so the bound checker can observe them.
  logic rx_sync;
  logic edge_evt;
  logic mid_evt;
  logic mid_bit;
  logic hunt;

  mdec_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  mdec_edge_timer #(.OSR(OSR)) timer_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_s_i(rx_sync),
    .edge_o(edge_evt),
    .mid_o (mid_evt),
    .bit_o (mid_bit),
    .hunt_o(hunt)
  );

  mdec_clkgen #(.OSR(OSR)) clkgen_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mid_i  (mid_evt),
    .bit_i  (mid_bit),
    .rclk_o (rclk_o),
    .datan_o(datan_o)
  );

endmodule

// File: rtl/mdec_chk.sv
module mdec_chk
  import mdec_pkg::*;
#(
  parameter int OSR = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rclk_i,
  input logic datan_i,
  input logic edge_i,
  input logic mid_i,
  input logic hunt_i
);

  localparam int HALF   = low_len(OSR);
  localparam int MINGAP = mid_gap_min(OSR);
  localparam int SAT    = 4 * OSR;
  localparam int SW     = $clog2(SAT + 1);

  logic [SW-1:0] low_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      since_q <= SW'(SAT);
    end else begin
      if (rclk_i) low_q <= '0;
      else if (int'(low_q) != SAT) low_q <= low_q + 1'b1;
      if (mid_i) since_q <= '0;
      else if (int'(since_q) != SAT) since_q <= since_q + 1'b1;
    end
  end

  AST_FALL_AFTER_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rclk_i) |-> $past(mid_i)); // R3

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(datan_i) |-> $fell(rclk_i)); // R4

  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rclk_i) |-> int'(low_q) == HALF); // R5

  AST_MID_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_i |-> edge_i); // R6

  AST_MID_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_i && !hunt_i) |-> (int'(since_q) + 1) >= MINGAP); // R6

  AST_HUNT_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |-> rclk_i); // R7

endmodule

bind mdec_top mdec_chk #(.OSR(OSR)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rclk_i (rclk_o),
  .datan_i(datan_o),
  .edge_i (edge_evt),
  .mid_i  (mid_evt),
  .hunt_i (hunt)
);

// File: tb/mdec_top_tb.sv
`timescale 1ns/1ps
module mdec_top_tb_top;

  localparam int OSR  = 8;
  localparam int SYNC = 2;
  localparam int HALF = OSR / 2;
  localparam int NB   = 9;

  // {half-cell in ps [55:40], bit count [39:32], bits, first sent = bit 0}
  localparam logic [55:0] TBL [NB] = '{
    {16'd20000, 8'd16, 32'h0000_A5C2},
    {16'd20000, 8'd32, 32'hDEAD_BEEE},
    {16'd17391, 8'd24, 32'h00F0_F0F0},
    {16'd17391, 8'd32, 32'h9669_6996},
    {16'd23529, 8'd32, 32'h5555_AAAA},
    {16'd23529, 8'd20, 32'h000F_FFF0},
    {16'd20000, 8'd1,  32'h0000_0000},
    {16'd17391, 8'd32, 32'hFFFF_FFFE},
    {16'd23529, 8'd32, 32'h8000_0000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b0;
  logic rclk_o, datan_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  bit          mon_en = 1'b0;
  logic        prev_rclk = 1'b1;
  logic        prev_datan = 1'b1;
  int          low_run = 0;
  int          got_n = 0;
  logic [63:0] got = '0;

  always #2.5 clk = ~clk;

  mdec_top #(.OSR(OSR), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rclk_o (rclk_o),
    .datan_o(datan_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Recovered-clock monitor, sampling away from the active edge.
  always @(negedge clk) begin
    if (mon_en) begin
      if (!rclk_o) low_run++;
      if (rclk_o && !prev_rclk) begin
        chk(low_run == HALF, "R5 low width", low_run, HALF);
        if (got_n < 64) got[got_n] = ~datan_o;
        got_n++;
        low_run = 0;
      end
      if (datan_o !== prev_datan)
        chk(prev_rclk && !rclk_o, "R4 data moved off falling edge", int'(rclk_o), 0);
    end
    prev_rclk  = rclk_o;
    prev_datan = datan_o;
  end

  task automatic clear_rx();
    got_n   = 0;
    got     = '0;
    low_run = 0;
  endtask

  task automatic send_burst(input real half, input int nb, input logic [31:0] d);
    for (int k = 0; k < nb; k++) begin
      rx_i = d[k];
      #(half);
      rx_i = ~d[k];
      #(half);
    end
    rx_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(500_000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    wait_cyc(3);
    chk(rclk_o == 1'b1, "R9 rclk in reset", int'(rclk_o), 1);
    chk(datan_o == 1'b1, "R9 datan in reset", int'(datan_o), 1);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(rclk_o == 1'b1, "R9 rclk after reset", int'(rclk_o), 1);
    chk(datan_o == 1'b1, "R9 datan after reset", int'(datan_o), 1);
    mon_en = 1'b1;

    // Table of bursts: R1, R2, R6, R8
    for (int i = 0; i < NB; i++) begin
      real         half;
      int          nb;
      logic [31:0] d;
      half = real'(TBL[i][55:40]) / 1000.0;
      nb   = int'(TBL[i][39:32]);
      d    = TBL[i][31:0];
      clear_rx();
      @(negedge clk);
      send_burst(half, nb, d);
      wait_cyc(60);
      chk(got_n == nb, "R2 R8 rising edges per burst", got_n, nb);
      for (int k = 0; k < nb; k++)
        chk(got[k] == d[k], "R1 R8 decoded bit", int'(got[k]), int'(d[k]));
    end

    // R3 and R7: rising edge out of hunt, latency and decoded zero
    clear_rx();
    @(negedge clk);
    rx_i = 1'b1;
    for (int k = 0; k < SYNC; k++) @(posedge clk);
    @(negedge clk);
    chk(rclk_o == 1'b1, "R3 rclk before latency", int'(rclk_o), 1);
    @(posedge clk);
    @(negedge clk);
    chk(rclk_o == 1'b0, "R3 rclk falls at latency", int'(rclk_o), 0);
    chk(datan_o == 1'b1, "R1 rising edge gives zero", int'(datan_o), 1);
    wait_cyc(40);
    chk(rclk_o == 1'b1, "R7 rclk high in hunt", int'(rclk_o), 1);

    // R7: falling edge out of hunt decodes a one
    rx_i = 1'b0;
    wait_cyc(SYNC + 1);
    chk(rclk_o == 1'b0, "R7 falling edge accepted", int'(rclk_o), 0);
    chk(datan_o == 1'b0, "R1 falling edge gives one", int'(datan_o), 0);
    wait_cyc(40);
    chk(got_n == 2, "R7 pulses from hunt", got_n, 2);

    // R6: second transition 5 cycles later is ignored
    clear_rx();
    rx_i = 1'b1;
    wait_cyc(5);
    rx_i = 1'b0;
    wait_cyc(12);
    chk(datan_o == 1'b1, "R6 early edge ignored data", int'(datan_o), 1);
    chk(got_n == 1, "R6 early edge ignored clock", got_n, 1);
    wait_cyc(40);

    // R6: second transition 6 cycles later is accepted
    clear_rx();
    rx_i = 1'b1;
    wait_cyc(6);
    rx_i = 1'b0;
    wait_cyc(12);
    chk(datan_o == 1'b0, "R6 edge at threshold accepted", int'(datan_o), 0);
    chk(got_n == 2, "R6 pulses at threshold", got_n, 2);
    wait_cyc(40);

    // R9: reset in the middle of a low pulse
    mon_en = 1'b0;
    rx_i = 1'b1;
    wait_cyc(SYNC + 2);
    chk(rclk_o == 1'b0, "R5 pulse in progress", int'(rclk_o), 0);
    rst_ni = 1'b0;
    rx_i   = 1'b0;
    @(negedge clk);
    chk(rclk_o == 1'b1, "R9 reset releases clock", int'(rclk_o), 1);
    chk(datan_o == 1'b1, "R9 reset clears data", int'(datan_o), 1);
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(4);
    chk(rclk_o == 1'b1, "R9 idle after reset", int'(rclk_o), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule